// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port with Half-Duplex Driver Control

This block is a full-duplex asynchronous serial transmitter and receiver for RS232, RS422 or RS485 line drivers. The frame format is chosen at run time: 7 or 8 data bits, 1 or 2 stop bits, and one of five parity modes. A divisor input sets a 16x oversampling tick, and one bit lasts 16 ticks. Line rates up to 12 Mbaud are possible when the clock runs at 192 MHz or faster with a divisor of zero.

The system side has two byte streams that use valid/ready. On the transmit stream the block raises `tx_ready` only when the transmitter is idle and the clear-to-send input is asserted. A byte moves when `tx_valid` and `tx_ready` are both high on a clock edge. The source keeps `tx_valid` and `tx_data` steady until that edge. On the receive stream, `rx_valid` and the byte and error flags stay stable until the sink raises `rx_ready`. A character that completes while the receive holding register is still full is dropped. The request-to-send output tells the far end whether the holding register can take a character.

For half-duplex RS485 use, `tx_en` turns on the line driver one bit time before the start bit. It turns the driver off only once the last stop bit has fully ended.

Top module: `uart485_core`

## Requirements
- R1: The idle line is high. A frame is a low start bit, then the data bits least significant bit first, then the optional parity bit, then high stop bits. Each bit lasts 16*(cfg_div+1) clock cycles.
- R2: When cfg_data8=1 a character has 8 data bits. When cfg_data8=0 it has 7: bit 7 is not sent, and received characters report bit 7 as 0.
- R3: The cfg_parity code selects parity. 0 is none, 1 is odd (the data ones plus the parity bit give an odd count), 2 is even, 3 is mark (parity bit always 1) and 4 is space (parity bit always 0). Codes 5 to 7 behave as none.
- R4: While cts_n is high, tx_ready stays low and no frame starts. A frame already running still completes.
- R5: tx_en rises one bit time before the start bit, within one tick period. It stays high until the last stop bit has completed and is low at all other times.
- R6: cfg_stop2=1 sends two stop bits and cfg_stop2=0 sends one. The receiver checks every configured stop bit.
- R7: The receiver confirms a start bit at mid-bit and samples each later bit at its centre. It presents the character on rx_data with rx_valid, and holds both until rx_ready is high on a clock edge.
- R8: rx_frame_err is set when any stop bit samples low. rx_parity_err is set when a parity mode is active and the received parity bit does not match it. Both flags travel with their character.
- R9: rts_n is low exactly while the receive holding register is empty. A character that completes while the register is full is discarded.
- R10: The transmitter captures the data byte and the frame format when the byte is accepted. A change to the cfg inputs during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 16 | Oversampling tick period minus one, in clock cycles |
| cfg_data8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_parity | input | 3 | Parity code (see R3) |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Received character held |
| rx_ready | input | 1 | Sink takes the held character |
| rx_frame_err | output | 1 | Stop bit error for the held character |
| rx_parity_err | output | 1 | Parity error for the held character |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Active-low clear to send |
| rts_n | output | 1 | Active-low request to send |
| tx_en | output | 1 | Line-driver enable for RS485 |

## Verification
The hardest situations to reach are a stop bit that samples low, and a character that arrives while the holding register is still full. Neither happens with a well-behaved link. The bench drives the receive line from its own serializer, which can flip the parity bit or pull the first stop bit low. It also sends two characters without reading the first. Transmit frames are decoded by a bench-side sampler that times each bit from the start edge. A directed case changes the frame format in the middle of a frame, and another holds clear-to-send off while a byte is waiting.

// File: rtl/uart485_pkg.sv
package uart485_pkg;
  localparam int DATA_W = 8;

  localparam logic [2:0] PAR_NONE  = 3'd0;
  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_EVEN  = 3'd2;
  localparam logic [2:0] PAR_MARK  = 3'd3;
  localparam logic [2:0] PAR_SPACE = 3'd4;

  // true when the code selects a parity bit in the frame
  function automatic logic par_enabled(input logic [2:0] mode);
    return (mode == PAR_ODD) || (mode == PAR_EVEN) ||
           (mode == PAR_MARK) || (mode == PAR_SPACE);
  endfunction

  // parity bit value for a character under a mode
  function automatic logic par_value(input logic [2:0] mode,
                                     input logic [DATA_W-1:0] d,
                                     input logic wide);
    logic x;
    x = ^{d[DATA_W-1] & wide, d[DATA_W-2:0]};
    case (mode)
      PAR_ODD:  return ~x;
      PAR_EVEN: return x;
      PAR_MARK: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/uart485_tick.sv
module uart485_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart485_tx.sv
module uart485_tx
  import uart485_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_data8,
  input  logic              cfg_stop2,
  input  logic [2:0]        cfg_parity,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              cts_n,
  output logic              txd,
  output logic              tx_en
);
  localparam int OSR_W = $clog2(OSR);
  localparam logic [OSR_W-1:0] SUB_LAST = OSR_W'(OSR - 1);
  localparam int BIT_W = $clog2(DATA_W);

  typedef enum logic [2:0] {T_IDLE, T_LEAD, T_START, T_DATA, T_PAR, T_STOP} tx_st_e;

  tx_st_e            st;
  logic [OSR_W-1:0]  sub;
  logic [BIT_W-1:0]  bitn;
  logic              stop_ix;
  logic [DATA_W-1:0] sh;
  logic              pbit, l_d8, l_s2, l_pen;

  assign in_ready = (st == T_IDLE) && !cts_n;
  assign tx_en    = (st != T_IDLE);

  always_comb begin
    case (st)
      T_START: txd = 1'b0;
      T_DATA:  txd = sh[0];
      T_PAR:   txd = pbit;
      default: txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= T_IDLE;
      sub     <= '0;
      bitn    <= '0;
      stop_ix <= 1'b0;
      sh      <= '0;
      pbit    <= 1'b0;
      l_d8    <= 1'b1;
      l_s2    <= 1'b0;
      l_pen   <= 1'b0;
    end else if (st == T_IDLE) begin
      if (in_valid && in_ready) begin
        sh    <= in_data;
        l_d8  <= cfg_data8;
        l_s2  <= cfg_stop2;
        l_pen <= par_enabled(cfg_parity);
        pbit  <= par_value(cfg_parity, in_data, cfg_data8);
        sub   <= '0;
        st    <= T_LEAD;
      end
    end else if (tick) begin
      if (sub != SUB_LAST) begin
        sub <= sub + 1'b1;
      end else begin
        sub <= '0;
        case (st)
          T_LEAD:  st <= T_START;
          T_START: begin
            st   <= T_DATA;
            bitn <= '0;
          end
          T_DATA: begin
            sh <= sh >> 1;
            if (bitn == (l_d8 ? BIT_W'(DATA_W - 1) : BIT_W'(DATA_W - 2))) begin
              st      <= l_pen ? T_PAR : T_STOP;
              stop_ix <= 1'b0;
            end else begin
              bitn <= bitn + 1'b1;
            end
          end
          T_PAR: begin
            st      <= T_STOP;
            stop_ix <= 1'b0;
          end
          T_STOP: begin
            if (stop_ix == l_s2) st <= T_IDLE;
            else stop_ix <= 1'b1;
          end
          default: st <= T_IDLE;
        endcase
      end
    end
  end

  AST_CTS_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_n && !tx_en) |=> !tx_en); // R4
  AST_ACCEPT_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> tx_en); // R5
  AST_LEAD_IDLES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> txd); // R5
  AST_START_INSIDE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> (tx_en && $past(tx_en))); // R5
  AST_ENDS_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> $past(txd)); // R6
endmodule

// File: rtl/uart485_rx.sv
module uart485_rx
  import uart485_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_data8,
  input  logic              cfg_stop2,
  input  logic [2:0]        cfg_parity,
  input  logic              rxd,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_ferr,
  output logic              out_perr,
  output logic              rts_n
);
  localparam int OSR_W = $clog2(OSR);
  localparam logic [OSR_W-1:0] SUB_LAST = OSR_W'(OSR - 1);
  localparam logic [OSR_W-1:0] SUB_MID  = OSR_W'(OSR / 2 - 1);
  localparam int BIT_W = $clog2(DATA_W);

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_WAIT} rx_st_e;

  rx_st_e            st;
  logic [1:0]        sync;
  logic              rxs;
  logic [OSR_W-1:0]  sub;
  logic [BIT_W-1:0]  bitn;
  logic              stop_ix, fe_acc, pe_acc;
  logic [DATA_W-1:0] sh, word;

  assign rxs   = sync[1];
  assign word  = cfg_data8 ? sh : {1'b0, sh[DATA_W-1:1]};
  assign rts_n = out_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= R_IDLE;
      sub       <= '0;
      bitn      <= '0;
      stop_ix   <= 1'b0;
      fe_acc    <= 1'b0;
      pe_acc    <= 1'b0;
      sh        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ferr  <= 1'b0;
      out_perr  <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (st == R_WAIT) begin
        if (rxs) st <= R_IDLE;
      end else if (tick) begin
        case (st)
          R_IDLE: begin
            if (!rxs) begin
              st  <= R_START;
              sub <= '0;
            end
          end
          R_START: begin
            if (sub != SUB_MID) begin
              sub <= sub + 1'b1;
            end else if (!rxs) begin
              st     <= R_DATA;
              sub    <= '0;
              bitn   <= '0;
              fe_acc <= 1'b0;
              pe_acc <= 1'b0;
            end else begin
              st <= R_IDLE;
            end
          end
          default: begin
            if (sub != SUB_LAST) begin
              sub <= sub + 1'b1;
            end else begin
              sub <= '0;
              if (st == R_DATA) begin
                sh <= {rxs, sh[DATA_W-1:1]};
                if (bitn == (cfg_data8 ? BIT_W'(DATA_W - 1) : BIT_W'(DATA_W - 2))) begin
                  st      <= par_enabled(cfg_parity) ? R_PAR : R_STOP;
                  stop_ix <= 1'b0;
                end else begin
                  bitn <= bitn + 1'b1;
                end
              end else if (st == R_PAR) begin
                pe_acc  <= (rxs != par_value(cfg_parity, word, cfg_data8));
                st      <= R_STOP;
                stop_ix <= 1'b0;
              end else if (stop_ix == cfg_stop2) begin
                if (!out_valid) begin
                  out_valid <= 1'b1;
                  out_data  <= word;
                  out_ferr  <= fe_acc | ~rxs;
                  out_perr  <= pe_acc;
                end
                st <= rxs ? R_IDLE : R_WAIT;
              end else begin
                fe_acc  <= fe_acc | ~rxs;
                stop_ix <= 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ferr))); // R7
  AST_SEVEN_BIT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && !cfg_data8) |-> !out_data[DATA_W-1]); // R2
  AST_READ_FREES_RTS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !rts_n); // R9
  AST_NO_PERR_WITHOUT_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && !par_enabled(cfg_parity)) |-> !out_perr); // R8
endmodule

// File: rtl/uart485_core.sv
module uart485_core
  import uart485_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OSR   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_data8,
  input  logic              cfg_stop2,
  input  logic [2:0]        cfg_parity,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_frame_err,
  output logic              rx_parity_err,
  output logic              txd,
  input  logic              rxd,
  input  logic              cts_n,
  output logic              rts_n,
  output logic              tx_en
);
  logic tick;

  uart485_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick)
  );

  uart485_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_data8(cfg_data8), .cfg_stop2(cfg_stop2), .cfg_parity(cfg_parity),
    .in_data(tx_data), .in_valid(tx_valid), .in_ready(tx_ready),
    .cts_n(cts_n), .txd(txd), .tx_en(tx_en)
  );

  uart485_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_data8(cfg_data8), .cfg_stop2(cfg_stop2), .cfg_parity(cfg_parity),
    .rxd(rxd), .out_data(rx_data), .out_valid(rx_valid), .out_ready(rx_ready),
    .out_ferr(rx_frame_err), .out_perr(rx_parity_err), .rts_n(rts_n)
  );
endmodule

// File: tb/uart485_core_test.sv
`timescale 1ns/1ps
module uart485_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg_div = 16'd1;
  logic cfg_data8 = 1'b1, cfg_stop2 = 1'b0;
  logic [2:0] cfg_parity = 3'd0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, rx_ready = 1'b0, rxd = 1'b1, cts_n = 1'b0;
  logic tx_ready, rx_valid, rx_frame_err, rx_parity_err, txd, rts_n, tx_en;
  logic [7:0] rx_data;

  int checks = 0, errors = 0;
  bit finished = 0;
  realtime t_rise = 0;

  always #2 clk = ~clk;

  uart485_core uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_data8(cfg_data8),
    .cfg_stop2(cfg_stop2), .cfg_parity(cfg_parity), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_frame_err(rx_frame_err),
    .rx_parity_err(rx_parity_err), .txd(txd), .rxd(rxd), .cts_n(cts_n),
    .rts_n(rts_n), .tx_en(tx_en)
  );

  always @(posedge tx_en) t_rise = $realtime;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int bit_clks();
    return 16 * (int'(cfg_div) + 1);
  endfunction

  function automatic bit has_par(input logic [2:0] p);
    return p >= 3'd1 && p <= 3'd4;
  endfunction

  function automatic logic par_of(input logic [7:0] d, input bit d8, input logic [2:0] p);
    int ones = 0;
    for (int i = 0; i < 8; i++) if (i < 7 || d8) ones += int'(d[i]);
    case (p)
      3'd1: return (ones % 2 == 0);
      3'd2: return (ones % 2 == 1);
      3'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int frame_len(input bit d8, input bit s2, input logic [2:0] p);
    return 1 + (d8 ? 8 : 7) + int'(has_par(p)) + (s2 ? 2 : 1);
  endfunction

  // bit i of the result is the i-th bit on the line, start bit first
  function automatic logic [15:0] frame_bits(input logic [7:0] d, input bit d8,
                                             input bit s2, input logic [2:0] p);
    logic [15:0] f = '1;
    int k = 1;
    f[0] = 1'b0;
    for (int i = 0; i < (d8 ? 8 : 7); i++) begin f[k] = d[i]; k++; end
    if (has_par(p)) begin f[k] = par_of(d, d8, p); k++; end
    return f;
  endfunction

  task automatic offer_tx(input logic [7:0] d);
    @(negedge clk);
    tx_data = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    #1 tx_valid = 1'b0;
  endtask

  // samples txd at each bit centre from the start edge, then checks the driver enable
  task automatic capture_tx(input logic [7:0] d, input bit d8, input bit s2, input logic [2:0] p,
                            input string req);
    int n = frame_len(d8, s2, p);
    int b = bit_clks();
    logic [15:0] got = '1;
    logic [15:0] exp = frame_bits(d, d8, s2, p);
    realtime lead;
    @(negedge txd);
    lead = ($realtime - t_rise) / 4.0;
    chk(tx_en && lead >= real'(b - int'(cfg_div)) && lead <= real'(b), "R5",
        "enable lead cycles", 32'(int'(lead)), 32'(b));
    repeat (b / 2) @(posedge clk);
    #1 got[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (b) @(posedge clk);
      #1 got[i] = txd;
    end
    for (int i = n; i < 16; i++) got[i] = 1'b1;
    chk(got == exp, req, "tx frame bits", 32'(got), 32'(exp));
    repeat (b / 2 - 1) @(posedge clk);
    #1 chk(tx_en == 1'b1, "R5", "enable before stop end", 32'(tx_en), 32'd1);
    @(posedge clk);
    #1 chk(tx_en == 1'b0, "R5", "enable after stop end", 32'(tx_en), 32'd0);
  endtask

  task automatic drive_rx(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int n = frame_len(cfg_data8, cfg_stop2, cfg_parity);
    logic [15:0] f = frame_bits(d, cfg_data8, cfg_stop2, cfg_parity);
    int sp = n - (cfg_stop2 ? 2 : 1);
    if (bad_par && has_par(cfg_parity)) f[sp - 1] = ~f[sp - 1];
    if (bad_stop) f[sp] = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1 rxd = f[i];
      repeat (bit_clks() - 1) @(posedge clk);
    end
    @(posedge clk);
    #1 rxd = 1'b1;
    repeat (2 * bit_clks()) @(posedge clk);
  endtask

  task automatic read_rx();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic rx_case(input logic [7:0] d, input bit bad_par, input bit bad_stop, input string req);
    logic [7:0] e = cfg_data8 ? d : {1'b0, d[6:0]};
    drive_rx(d, bad_par, bad_stop);
    @(negedge clk);
    chk(rx_valid == 1'b1, "R7", "rx valid", 32'(rx_valid), 32'd1);
    chk(rx_data == e, req, "rx data", 32'(rx_data), 32'(e));
    chk(rx_frame_err == bad_stop, "R8", "frame err", 32'(rx_frame_err), 32'(bad_stop));
    chk(rx_parity_err == (bad_par && has_par(cfg_parity)), "R8", "parity err",
        32'(rx_parity_err), 32'(bad_par && has_par(cfg_parity)));
    read_rx();
    chk(rts_n == 1'b0 && rx_valid == 1'b0, "R9", "holding freed", 32'(rts_n), 32'd0);
  endtask

  task automatic tx_case(input logic [7:0] d, input string req);
    fork
      offer_tx(d);
      capture_tx(d, cfg_data8, cfg_stop2, cfg_parity, req);
    join
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0c0d);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1 && tx_en == 1'b0, "R5", "reset line idle", {txd, tx_en}, 32'h2);
    chk(rx_valid == 1'b0 && rts_n == 1'b0, "R9", "reset holding empty", {rx_valid, rts_n}, 32'h0);
    chk(tx_ready == 1'b1, "R4", "reset ready with cts", 32'(tx_ready), 32'd1);

    // fastest tick: one bit is 16 clocks
    cfg_div = 16'd0;
    tx_case(8'hA5, "R1");
    rx_case(8'h3C, 1'b0, 1'b0, "R7");
    cfg_div = 16'd1;

    // each parity mode, including an unused code
    for (int p = 0; p < 6; p++) begin
      cfg_parity = 3'(p);
      tx_case(8'h4D, "R3");
      rx_case(8'hB2, 1'b0, 1'b0, "R3");
    end
    cfg_parity = 3'd2;
    rx_case(8'h71, 1'b1, 1'b0, "R8");
    cfg_stop2 = 1'b1;
    tx_case(8'hF0, "R6");
    rx_case(8'h0F, 1'b0, 1'b1, "R6");
    cfg_stop2 = 1'b0;
    rx_case(8'h55, 1'b0, 1'b1, "R8");
    cfg_data8 = 1'b0;
    tx_case(8'hFF, "R2");
    rx_case(8'hC3, 1'b0, 1'b0, "R2");
    cfg_data8 = 1'b1;

    // format changed in mid frame: the frame keeps the accepted format
    cfg_parity = 3'd1;
    fork
      offer_tx(8'h96);
      capture_tx(8'h96, 1'b1, 1'b0, 3'd1, "R10");
      begin
        @(posedge tx_en);
        #1 cfg_data8 = 1'b0;
        cfg_parity = 3'd0;
        cfg_stop2 = 1'b1;
      end
    join
    cfg_data8 = 1'b1; cfg_parity = 3'd0; cfg_stop2 = 1'b0;

    // clear-to-send withheld while a byte waits
    cts_n = 1'b1;
    fork
      offer_tx(8'h3A);
      capture_tx(8'h3A, 1'b1, 1'b0, 3'd0, "R4");
      begin
        repeat (3 * bit_clks()) @(negedge clk);
        chk(tx_en == 1'b0 && txd == 1'b1 && tx_ready == 1'b0, "R4", "held off",
            {tx_en, txd, tx_ready}, 32'h2);
        cts_n = 1'b0;
      end
    join

    // second character while full is dropped
    drive_rx(8'h11, 1'b0, 1'b0);
    @(negedge clk);
    chk(rts_n == 1'b1, "R9", "rts while full", 32'(rts_n), 32'd1);
    drive_rx(8'h22, 1'b0, 1'b0);
    @(negedge clk);
    chk(rx_valid && rx_data == 8'h11, "R7", "held first character", 32'(rx_data), 32'h11);
    read_rx();
    chk(rx_valid == 1'b0, "R9", "second character discarded", 32'(rx_valid), 32'd0);

    // random frames
    for (int i = 0; i < 20; i++) begin
      logic [7:0] d = 8'($urandom);
      cfg_data8  = 1'($urandom);
      cfg_stop2  = 1'($urandom);
      cfg_parity = 3'($urandom % 8);
      if ($urandom % 2) tx_case(d, "R1");
      else rx_case(d, ($urandom % 4) == 0, ($urandom % 5) == 0, "R7");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule